// File: doc/BRIEF.md
# Accelerometer FIFO Drain Sequencer

This block empties an accelerometer's sample FIFO over SPI without any software involvement. It sits above a byte-level SPI master: it hands that master one byte at a time and controls the chip-select line itself. One `start` pulse runs a full drain. The sequencer first reads the interrupt-source register and the FIFO-status register, each in its own two-byte transaction. It then runs one seven-byte burst per stored entry: a multi-byte read command aimed at the first data register, followed by six dummy bytes that clock out the X, Y and Z sample halves.

Between any two transactions the chip select is held high for a programmable number of clock cycles. The sensor needs this gap to pop the next FIFO entry. Each completed burst produces one 48-bit sample on a valid/ready stream, together with the overrun bit taken from the interrupt-source read. A consumer that is not ready holds the sequencer between bursts, never inside one. `busy` covers the whole drain, and `done` pulses once at the end.

Top module: `accel_drain_seq`

## Requirements
- R1: After reset, `busy`, `done`, `spi_req` and `smp_valid` are low and `cs_n` is high.
- R2: The first transaction after `start` is exactly 2 bytes inside one chip-select low window: command 0xB0 (bit 7 = read, bit 6 = multi-byte 0, bits 5:0 = address 0x30), then 0x00.
- R3: The second transaction is a separate 2-byte window: command 0xB9 (address 0x39, multi-byte 0), then 0x00.
- R4: Every later transaction is a 7-byte window: command 0xF2 (read, multi-byte 1, address 0x32), then six 0x00 bytes.
- R5: Between the end of one chip-select window and the start of the next, `cs_n` stays high for at least GAP_CYCLES clock cycles.
- R6: The number of bursts equals bits 5:0 of the byte received in the second transaction, limited to MAX_ENTRIES (32 by default); bits 7:6 of that byte are ignored.
- R7: When that count is zero, no burst is issued and the drain ends after the second transaction's gap.
- R8: Each burst yields one sample. `smp_data[8*i+7:8*i]` holds the i-th byte received after the command byte (i = 0..5), and `smp_ovr` equals bit 0 of the byte received in the first transaction.
- R9: `smp_valid` is only asserted while `cs_n` is high. While `smp_valid` is high and `smp_ready` is low, the sample stays unchanged and no new window opens.
- R10: `busy` rises in the cycle after an idle `start` and falls when `done` pulses for exactly one cycle. A `start` pulse while busy has no effect.
- R11: `spi_req` is a one-cycle pulse, asserted only while `cs_n` is low and only after the previous byte's `spi_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse to begin a drain |
| busy | output | 1 | Drain in progress |
| done | output | 1 | One-cycle pulse at the end of a drain |
| spi_req | output | 1 | Request one byte exchange from the SPI master |
| spi_tx | output | 8 | Byte to send |
| spi_ack | input | 1 | Byte exchange finished, `spi_rx` valid |
| spi_rx | input | 8 | Byte received |
| cs_n | output | 1 | Sensor chip select, active low |
| smp_valid | output | 1 | Sample available |
| smp_ready | input | 1 | Consumer accepts the sample |
| smp_data | output | 48 | Six sample bytes, first received in bits 7:0 |
| smp_ovr | output | 1 | Overrun flag for the current drain |

## Verification
The bench sweeps the reported entry count from 0 through 33, plus status bytes with the upper bits set and values above the limit. This catches a sequencer that issues one burst too many or too few, decodes the upper status bits, or fails to clamp at 32. A zero count must end the drain right after the status read; a design that tested the count too late would run a spurious burst. Every chip-select window is measured for byte count, command byte and the high time before it, so a merged window or a short gap shows up. Consumer stall patterns check that a blocked sample freezes the data and keeps the chip select high, rather than being overwritten by the next burst.

// File: rtl/accel_drain_pkg.sv
// Shared constants and types for the FIFO drain sequencer.
// Assumes the sensor read command format {read, multi_byte, addr[5:0]}.
package accel_drain_pkg;
    localparam logic [5:0] REG_INT_SRC = 6'h30;
    localparam logic [5:0] REG_FIFO_ST = 6'h39;
    localparam logic [5:0] REG_DATA0   = 6'h32;
    localparam int         SAMPLE_BYTES = 6;
    localparam int         CNT_FIELD_W  = 6;

    typedef enum logic [1:0] {TX_INT, TX_STAT, TX_BURST} txn_e;
    typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_GAP} state_e;

    // Build a read command byte.
    function automatic logic [7:0] rd_cmd(input logic [5:0] addr, input logic multi);
        return {1'b1, multi, addr};
    endfunction
endpackage

// File: rtl/drain_gap_timer.sv
// Counts the chip-select high gap. Loading starts a count of GAP_CYCLES;
// expired is high once the count has run out. Assumes GAP_CYCLES >= 1.
module drain_gap_timer #(
    parameter int GAP_CYCLES = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int W = $clog2(GAP_CYCLES + 1);
    localparam logic [W-1:0] LOAD_VAL = W'(GAP_CYCLES);

    logic [W-1:0] cnt;

    // Load on request, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= LOAD_VAL;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    p_load_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !expired);
endmodule

// File: rtl/drain_sample_asm.sv
// Assembles a sample from serial bytes: each shift moves every lane down
// by one byte and puts the new byte in the top lane, so after NBYTES shifts
// the first byte sits in lane 0. Assumes the shift count is managed outside.
module drain_sample_asm #(
    parameter int NBYTES = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic [7:0]        byte_in,
    output logic [8*NBYTES-1:0] data
);
    for (genvar i = 0; i < NBYTES; i++) begin : g_lane
        // Each lane takes its upper neighbour, the top lane takes the input.
        always_ff @(posedge clk) begin
            if (!rst_n)        data[8*i +: 8] <= '0;
            else if (shift_en) data[8*i +: 8] <= (i == NBYTES-1) ? byte_in : data[8*(i+1) +: 8];
        end
    end
endmodule

// File: rtl/accel_drain_seq.sv
// FIFO drain sequencer. On start: reads the interrupt source, then the
// FIFO status, each in its own chip-select window, then runs one 7-byte burst
// per reported entry, with a timed chip-select high gap after every window.
// Assumes a byte-level SPI master that answers each spi_req with one spi_ack.
module accel_drain_seq
    import accel_drain_pkg::*;
#(
    parameter int GAP_CYCLES  = 250,
    parameter int MAX_ENTRIES = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    output logic        busy,
    output logic        done,
    output logic        spi_req,
    output logic [7:0]  spi_tx,
    input  logic        spi_ack,
    input  logic [7:0]  spi_rx,
    output logic        cs_n,
    output logic        smp_valid,
    input  logic        smp_ready,
    output logic [47:0] smp_data,
    output logic        smp_ovr
);
    localparam int CNT_W = $clog2(MAX_ENTRIES + 1);
    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_ENTRIES);

    state_e           state;
    txn_e             txn;
    logic [2:0]       bidx;
    logic [2:0]       last_idx;
    logic [CNT_W-1:0] remaining;
    logic [CNT_W-1:0] clamped;
    logic             gap_load, gap_done, shift_en, ack_now, more;
    logic [7:0]       cmd;

    // Byte index of the final byte in the current window.
    always_comb last_idx = (txn == TX_BURST) ? 3'd6 : 3'd1;

    // Command byte for the current transaction.
    always_comb begin
        case (txn)
            TX_INT:  cmd = rd_cmd(REG_INT_SRC, 1'b0);
            TX_STAT: cmd = rd_cmd(REG_FIFO_ST, 1'b0);
            default: cmd = rd_cmd(REG_DATA0, 1'b1);
        endcase
    end

    // Entry count from the status byte, limited to the FIFO depth.
    always_comb begin
        if (32'(spi_rx[CNT_FIELD_W-1:0]) > MAX_ENTRIES) clamped = MAX_CNT;
        else                                           clamped = CNT_W'(spi_rx[CNT_FIELD_W-1:0]);
    end

    assign ack_now  = (state == S_WAIT) && spi_ack;
    assign gap_load = ack_now && (bidx == last_idx);
    assign shift_en = ack_now && (txn == TX_BURST) && (bidx != 3'd0);
    assign spi_req  = (state == S_REQ);
    assign spi_tx   = (bidx == 3'd0) ? cmd : 8'h00;
    // Another window follows the one just finished.
    assign more     = (txn == TX_INT) || (remaining != '0);

    // Main sequencing: window bytes, gap wait, next-window decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            txn       <= TX_INT;
            bidx      <= '0;
            remaining <= '0;
            smp_ovr   <= 1'b0;
            cs_n      <= 1'b1;
            busy      <= 1'b0;
            done      <= 1'b0;
            smp_valid <= 1'b0;
        end else begin
            done <= 1'b0;
            if (smp_valid && smp_ready) smp_valid <= 1'b0;
            case (state)
                S_IDLE: if (start) begin
                    busy  <= 1'b1;
                    txn   <= TX_INT;
                    bidx  <= '0;
                    cs_n  <= 1'b0;
                    state <= S_REQ;
                end
                S_REQ: state <= S_WAIT;
                S_WAIT: if (spi_ack) begin
                    if (txn == TX_INT && bidx == 3'd1)  smp_ovr   <= spi_rx[0];
                    if (txn == TX_STAT && bidx == 3'd1) remaining <= clamped;
                    if (bidx == last_idx) begin
                        cs_n  <= 1'b1;
                        state <= S_GAP;
                        if (txn == TX_BURST) begin
                            smp_valid <= 1'b1;
                            remaining <= remaining - 1'b1;
                        end
                    end else begin
                        bidx  <= bidx + 1'b1;
                        state <= S_REQ;
                    end
                end
                S_GAP: if (gap_done && !smp_valid) begin
                    if (more) begin
                        txn   <= (txn == TX_INT) ? TX_STAT : TX_BURST;
                        bidx  <= '0;
                        cs_n  <= 1'b0;
                        state <= S_REQ;
                    end else begin
                        busy  <= 1'b0;
                        done  <= 1'b1;
                        state <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    drain_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (gap_load),
        .expired (gap_done)
    );

    drain_sample_asm #(.NBYTES(SAMPLE_BYTES)) u_asm (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .byte_in  (spi_rx),
        .data     (smp_data)
    );

    p_req_cs_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        spi_req |-> !cs_n);
    p_req_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        spi_req |=> !spi_req);
    p_valid_cs_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> cs_n);
    p_smp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid && !smp_ready |=> smp_valid && $stable(smp_data) && $stable(smp_ovr) && cs_n);
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    p_cnt_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        remaining <= MAX_CNT);
    p_cs_rise_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |=> cs_n);
endmodule

// File: tb/accel_drain_seq_tb.sv
// Bench: models the SPI master and sensor at the negative edge, sweeps the
// entry count and consumer stall patterns, checks every window and sample.
module accel_drain_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int GAP = 12;
    localparam int MAXE = 32;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic busy, done, spi_req, cs_n, smp_valid, smp_ovr;
    logic spi_ack = 1'b0, smp_ready = 1'b0;
    logic [7:0] spi_tx, spi_rx = 8'h00;
    logic [47:0] smp_data;

    int total = 0, bad = 0;
    int win_n = 0, pos = 0, hi_len = 0, ack_cnt = 0, lat = 1;
    int smp_k = 0, done_cnt = 0, cyc = 0, mode = 0, scen = 0, exp_b = 0;
    logic [7:0] int_val = 8'h00, stat_val = 8'h00;
    bit cs_prev = 1'b1, prev_done = 1'b0, stall_prev = 1'b0;
    logic [47:0] held;

    always #(CLK_PERIOD/2) clk = ~clk;

    accel_drain_seq #(.GAP_CYCLES(GAP), .MAX_ENTRIES(MAXE)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .spi_req(spi_req), .spi_tx(spi_tx), .spi_ack(spi_ack), .spi_rx(spi_rx),
        .cs_n(cs_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
        .smp_data(smp_data), .smp_ovr(smp_ovr)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] dat(input int b, input int i);
        return 8'((b * 7 + i * 29 + scen * 3) & 8'hFF);
    endfunction

    function automatic logic [47:0] exp_smp(input int b);
        logic [47:0] v;
        for (int i = 0; i < 6; i++) v[8*i +: 8] = dat(b, i + 1);
        return v;
    endfunction

    // SPI master, sensor and sample consumer model, all at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            spi_ack = 1'b0;
            if (ack_cnt > 0) begin
                ack_cnt--;
                if (ack_cnt == 0) spi_ack = 1'b1;
            end
            if (!rst_n) begin
                cs_prev = 1'b1;
            end else begin
                if (cs_n) begin
                    if (!cs_prev) begin
                        chk(pos == ((win_n < 2) ? 2 : 7), (win_n == 0) ? "R2 len" : (win_n == 1) ? "R3 len" : "R4 len",
                            pos, (win_n < 2) ? 2 : 7);
                        win_n++;
                        hi_len = 0;
                    end
                    hi_len++;
                end else if (cs_prev) begin
                    if (win_n > 0) chk(hi_len >= GAP, "R5 gap", hi_len, GAP);
                    chk(win_n < exp_b + 2, "R6 extra window", win_n, exp_b + 2);
                    pos = 0;
                end
                if (spi_req) begin
                    chk(!cs_n && ack_cnt == 0 && !spi_ack, "R11 req", cs_n, 0);
                    if (pos == 0)
                        chk(spi_tx == ((win_n == 0) ? 8'hB0 : (win_n == 1) ? 8'hB9 : 8'hF2),
                            (win_n == 0) ? "R2 cmd" : (win_n == 1) ? "R3 cmd" : "R4 cmd", spi_tx,
                            (win_n == 0) ? 8'hB0 : (win_n == 1) ? 8'hB9 : 8'hF2);
                    else
                        chk(spi_tx == 8'h00, "R4 dummy", spi_tx, 0);
                    if (win_n == 0)      spi_rx = int_val;
                    else if (win_n == 1) spi_rx = stat_val;
                    else                 spi_rx = dat(win_n - 2, pos);
                    if (pos == 0) spi_rx = 8'hEE;
                    pos++;
                    ack_cnt = lat;
                end
                // Consumer
                if (stall_prev) begin
                    chk(smp_valid && smp_data == held && cs_n, "R9 hold", smp_data, held);
                end
                if (smp_valid) chk(cs_n, "R9 cs high", cs_n, 1);
                case (mode)
                    0: smp_ready = 1'b1;
                    1: smp_ready = cyc[0];
                    default: smp_ready = (cyc % 30) >= 20;
                endcase
                stall_prev = smp_valid && !smp_ready;
                held = smp_data;
                if (smp_valid && smp_ready) begin
                    chk(smp_data == exp_smp(smp_k), "R8 data", smp_data, exp_smp(smp_k));
                    chk(smp_ovr == int_val[0], "R8 ovr", smp_ovr, int_val[0]);
                    smp_k++;
                end
                if (prev_done) chk(!done, "R10 done one cycle", done, 0);
                prev_done = done;
                if (done) begin
                    chk(!busy, "R10 busy low at done", busy, 0);
                    chk(win_n - 2 == exp_b, (exp_b == 0) ? "R7 no burst" : "R6 burst count", win_n - 2, exp_b);
                    chk(smp_k == exp_b, "R8 sample count", smp_k, exp_b);
                    done_cnt++;
                end
                cs_prev = cs_n;
            end
        end
    end

    task automatic run(input logic [7:0] st, input logic [7:0] iv, input int m, input bit restart);
        int e;
        e = int'(st[5:0]);
        exp_b = (e > MAXE) ? MAXE : e;
        stat_val = st; int_val = iv; mode = m;
        win_n = 0; smp_k = 0; scen++;
        lat = 1 + (scen % 2);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(busy, "R10 busy after start", busy, 1);
        if (restart) begin
            repeat (60) @(negedge clk);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        wait (done_cnt == scen);
        repeat (3) @(negedge clk);
        chk(done_cnt == scen && !busy, "R10 single done", done_cnt, scen);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !spi_req && !smp_valid && cs_n, "R1 reset", {busy, done, spi_req, smp_valid, cs_n}, 5'b00001);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !spi_req && !smp_valid && cs_n, "R1 after release", {busy, done, spi_req, smp_valid, cs_n}, 5'b00001);
        for (int n = 0; n <= 33; n++)
            run(8'(n), 8'(n), n % 3, n == 5);
        run(8'hC5, 8'h81, 1, 1'b0);   // R6 upper status bits ignored
        run(8'h3F, 8'h00, 0, 1'b0);   // R6 clamp to 32
        run(8'hC0, 8'h01, 2, 1'b0);   // R7 zero with upper bits set
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule